// File: doc/BRIEF.md
# Programmable Down-Count Timer Channel

This block is one timer channel that counts microseconds. A free-running prescaler elsewhere on the chip supplies a one-cycle tick enable once per microsecond. Software programs the channel through a 32-bit control word and a 32-bit status word. The control word arms the channel, picks between single-shot and repeating operation, and sets a 29-bit reload value. The channel then counts down one step on each tick. When the count runs out, it raises a level interrupt.

One programmed interval lasts reload + 1 ticks. A single-shot channel disarms itself at expiry and holds a count of zero. A repeating channel reloads and fires again every reload + 1 ticks. The interrupt stays high until software writes the clear bit in the status word. Reading the status word returns the count still remaining. Writing an all-zero control word stops the channel, and no expiry is left pending. Several channels of this kind can sit side by side, for example one per processor as a wake-up source. Only one channel is built here.

Top module: `tmr_channel`

## Requirements
- R1: After reset the interrupt is low, the control readback is 0 and the status readback is 0.
- R2: A control write stores bit 31 as the enable flag, bit 30 as the repeat flag (1 = periodic, 0 = one-shot) and bits 28:0 as the reload value. The readback shows these fields in the same positions and reads bit 29 as 0, whatever was written to it.
- R3: A control write loads the remaining count (status bits 28:0) with the reload value at the write edge. While the channel is enabled, the count drops by one only on cycles where tick_en is high.
- R4: With reload value V, the interrupt rises at the edge of the (V+1)-th tick after the control write, and not before.
- R5: At expiry in one-shot mode, the enable flag clears by itself and the count stays at 0. Later ticks raise no further interrupt.
- R6: At expiry in periodic mode, the count reloads to V and the interrupt is raised again after each further V+1 ticks.
- R7: Writing 0 to the control word stops the channel. Later ticks neither change the count nor raise the interrupt.
- R8: The interrupt is level-high and stays high until a status write with bit 30 set. A status write with bit 30 clear leaves it unchanged.
- R9: If a status clear and an expiry fall on the same edge, the interrupt stays high.
- R10: If a control write and a tick that would expire the count fall on the same edge, the write wins. The new value is loaded and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle microsecond tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control word, 1 = status word |
| wr_data | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control word readback |
| stat_rdata | output | 32 | Status readback, remaining count in bits 28:0 |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
Every result of this channel is registered once. A write, a tick or a clear shows up on the readbacks and on irq right after the clock edge where the stimulus was applied, and not a cycle later. The bench drives each stimulus shortly after an edge. It samples the outputs just after the following edge, so each check lands in the cycle the result is due. The bench sweeps reload values 0 to 5 in both modes, with a tick on every cycle and on every second cycle. It counts ticks to predict the exact expiry edge, and checks on the idle cycles that the count does not move.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W   = 32;
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int CLR_BIT = 30;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic             load_per,
  input  logic [CNT_W-1:0] load_val,
  input  logic             expire,
  output logic             en_q,
  output logic             per_q,
  output logic [CNT_W-1:0] reload_q
);
  logic             en_d;
  logic             per_d;
  logic [CNT_W-1:0] reload_d;

  always_comb begin
    en_d     = en_q;
    per_d    = per_q;
    reload_d = reload_q;
    if (load) begin
      en_d     = load_en;
      per_d    = load_per;
      reload_d = load_val;
    end else if (expire && !per_q) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      per_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      en_q     <= en_d;
      per_q    <= per_d;
      reload_q <= reload_d;
    end
  end

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !per_q |=> !en_q); // R5
  AST_REPEAT_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    expire && per_q && !load |=> en_q); // R6
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  assign step   = run && tick && !load;
  assign expire = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (expire) begin
      cnt_d = periodic ? reload : '0;
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !tick |=> $stable(cnt_q)); // R3
  AST_DECREMENT_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire && periodic |=> cnt_q == $past(reload)); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !load |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (expire)   irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  AST_SET_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_q); // R4
  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !clr |=> irq_q); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !expire |=> !irq_q); // R4
  AST_EXPIRY_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && expire |=> irq_q); // R9
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic [REG_W-1:0] stat_rdata,
  output logic             irq
);
  localparam int GAP_W = REG_W - 2 - CNT_W;

  logic             ctrl_wr;
  logic             clr_req;
  logic             en_q;
  logic             per_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             unused_wr_bits;

  assign ctrl_wr        = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign clr_req        = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT) && wr_data[CLR_BIT];
  assign unused_wr_bits = ^wr_data[REG_W-3:CNT_W];

  tmr_ctrl_reg #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctrl_wr),
    .load_en  (wr_data[EN_BIT]),
    .load_per (wr_data[PER_BIT]),
    .load_val (wr_data[CNT_W-1:0]),
    .expire   (expire),
    .en_q     (en_q),
    .per_q    (per_q),
    .reload_q (reload_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctrl_wr),
    .load_val (wr_data[CNT_W-1:0]),
    .run      (en_q),
    .periodic (per_q),
    .reload   (reload_q),
    .tick     (tick_en),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr    (clr_req),
    .irq_q  (irq)
  );

  assign ctrl_rdata = {en_q, per_q, {GAP_W{1'b0}}, reload_q};
  assign stat_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_q};

  AST_WRITE_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> stat_rdata[CNT_W-1:0] == $past(wr_data[CNT_W-1:0])); // R10
  AST_GAP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[REG_W-3:CNT_W] == '0); // R2
endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic [31:0] ctrl_rdata;
  logic [31:0] stat_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_rdata(ctrl_rdata),
    .stat_rdata(stat_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // drive for one edge, return 1 ns after it
  task automatic cyc(input logic t, input logic we, input logic sel, input logic [31:0] d);
    tick_en = t; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    tick_en = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] cword(input logic en, input logic per, input logic [28:0] v);
    return {en, per, 1'b0, v};
  endfunction

  localparam logic [31:0] CLR = 32'h4000_0000;

  initial begin
    tick_en = 0; wr_en = 0; wr_sel = 0; wr_data = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 ctrl", ctrl_rdata, 0);
    check("R1 stat", stat_rdata, 0);

    // R2: field storage, bit 29 ignored, max value
    cyc(0, 1, 0, 32'hFFFF_FFFF);
    check("R2 readback max", ctrl_rdata, 32'hDFFF_FFFF);
    check("R3 load max", stat_rdata, 32'h1FFF_FFFF);
    cyc(0, 1, 0, 32'h2000_0005);
    check("R2 bit29 dropped", ctrl_rdata, 32'h0000_0005);
    cyc(0, 1, 0, 0);
    check("R7 zero write", ctrl_rdata, 0);

    // sweep: value, mode, tick spacing
    for (int v = 0; v <= 5; v++) begin
      for (int p = 0; p <= 1; p++) begin
        for (int g = 1; g <= 2; g++) begin
          cyc(0, 1, 1, CLR);
          check("R8 clear", {31'd0, irq}, 0);
          cyc(0, 1, 0, cword(1, p[0], 29'(v)));
          check("R3 load", stat_rdata, v);
          check("R2 readback", ctrl_rdata, cword(1, p[0], 29'(v)));
          for (int rep = 0; rep < (p == 1 ? 2 : 1); rep++) begin
            for (int k = 1; k <= v + 1; k++) begin
              if (g == 2) begin
                cyc(0, 0, 0, 0);
                check("R3 hold no tick", stat_rdata, (k == 1) ? v : v - k + 1);
              end
              cyc(1, 0, 0, 0);
              if (k <= v) begin
                check("R3 decrement", stat_rdata, v - k);
                check("R4 no early irq", {31'd0, irq}, 0);
              end else begin
                check("R4 irq at expiry", {31'd0, irq}, 1);
              end
            end
            if (p == 1) begin
              check("R6 reload", stat_rdata, v);
              check("R6 still armed", {31'd0, ctrl_rdata[31]}, 1);
              cyc(0, 1, 1, CLR);
              check("R8 cleared", {31'd0, irq}, 0);
            end
          end
          if (p == 0) begin
            check("R5 disarmed", {31'd0, ctrl_rdata[31]}, 0);
            check("R5 count zero", stat_rdata, 0);
            for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0);
            check("R8 level held", {31'd0, irq}, 1);
            cyc(0, 1, 1, 32'h0000_0000);
            check("R8 no clear bit", {31'd0, irq}, 1);
            cyc(0, 1, 1, CLR);
            for (int k = 0; k <= v + 1; k++) cyc(1, 0, 0, 0);
            check("R5 no refire", {31'd0, irq}, 0);
            check("R5 stays zero", stat_rdata, 0);
          end
        end
      end
    end
    cyc(0, 1, 0, 0);

    // R7: stop mid-count
    cyc(0, 1, 1, CLR);
    cyc(0, 1, 0, cword(1, 1, 5));
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    check("R7 counted", stat_rdata, 3);
    cyc(0, 1, 0, 0);
    for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0);
    check("R7 stopped count", stat_rdata, 0);
    check("R7 no irq", {31'd0, irq}, 0);

    // R9: clear and expiry on same edge
    cyc(0, 1, 0, cword(1, 1, 0));
    cyc(1, 0, 0, 0);
    check("R9 setup irq", {31'd0, irq}, 1);
    cyc(1, 1, 1, CLR);
    check("R9 expiry wins", {31'd0, irq}, 1);
    cyc(0, 1, 1, CLR);
    check("R9 later clear", {31'd0, irq}, 0);

    // R10: control write and expiring tick on same edge
    cyc(0, 1, 0, cword(1, 0, 0));
    cyc(1, 1, 0, cword(1, 0, 3));
    check("R10 no irq", {31'd0, irq}, 0);
    check("R10 loaded", stat_rdata, 3);
    check("R10 armed", {31'd0, ctrl_rdata[31]}, 1);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0);
    check("R10 new interval", {31'd0, irq}, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule